// File: doc/BRIEF.md
# Indexed Remap Element Index Unit

This unit turns a linear vector loop step into the element index used by an indexed remap schedule. A configuration pulse captures the vector length limit, a dimension code, a transpose flag, a skip flag and a 5-bit base field. The unit then works out the second dimension by repeated subtraction, and copies the block of index registers that starts at the base register into a local cache through a narrow read port. After that, each step request is reshaped as linear, modulo-N or transposed, and then looked up in the cache.

The register number is the base field followed by two zero bits, which gives a 7-bit number spanning 128 registers. Register numbers wrap modulo 128. The cache is a snapshot: index registers that change after configuration have no effect until the next configuration. Division and modulo are computed by counters, so a result takes a variable number of cycles. The valid output holds the result until the next request.

Top module: `remap_idx_unit`

## Requirements
- R1: After reset, out_valid and busy are 0. A step_start before the first configuration is ignored: out_valid stays 0 and busy stays 0.
- R2: The base register number is {cfg_base, 2'b00}. Cache entry k is loaded from register (base + k) mod 128, and out_reg = (base + pos) mod 128, where pos is the reshaped position.
- R3: The dimension code is stored minus one: code c means xdim = c + 1, covering 1..32.
- R4: With yx=0, skip=0 and xdim > 1, pos = step mod xdim. This holds even when the vector length is not a multiple of xdim.
- R5: With yx=0 and either xdim = 1 or xdim at least the vector length, pos = step (linear indexing).
- R6: With yx=1 and skip=0, ydim = ceil(maxvl / xdim) and pos = (step mod ydim) * xdim + (step div ydim).
- R7: With skip=1, pos = step regardless of yx and the dimension code.
- R8: The cache holds the register contents read during configuration. Later changes to the index registers do not alter out_elem. An accepted cfg_start clears out_valid and raises busy on the next cycle. A maxvl code of 0 is treated as 1.
- R9: busy is high while configuring or computing a step, and out_valid is never high together with busy. Once out_valid rises, it stays high and out_elem and out_reg stay stable until the next step_start or cfg_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Configuration pulse, accepted when busy is low |
| cfg_maxvl | input | 7 | Vector length limit (0 treated as 1) |
| cfg_dim_code | input | 5 | First dimension minus one |
| cfg_yx | input | 1 | Transposed 2D mapping select |
| cfg_skip | input | 1 | Forces linear mapping |
| cfg_base | input | 5 | Upper bits of the index base register number |
| reg_rd_num | output | 7 | Register number fetched during cache load |
| reg_rd_data | input | 8 | Contents of the register at reg_rd_num (same cycle) |
| step_start | input | 1 | Request a mapped index, accepted when configured and not busy |
| step_idx | input | 7 | Linear loop step |
| busy | output | 1 | Configuration or step computation in progress |
| out_valid | output | 1 | Result valid, held until the next request |
| out_elem | output | 8 | Cached index value for the mapped position |
| out_reg | output | 7 | Register number holding that index |

## Verification
A wrong remainder or quotient in the iterative counters shows at the ports as a wrong out_reg on the first step whose mapping crosses a dimension boundary. In transposed mode this is step ydim; in modulo mode it is step xdim. A bad ydim therefore shows up within one pass over the vector. A wrong load count or a wrong load address shows as an out_elem that does not match the snapshot, at the first position that touches the missing entry. Register-number wrap past 127 is exercised with the highest base. A cache that is updated after configuration is exposed by rewriting the register model and stepping again.

// File: rtl/remap_idx_pkg.sv
// Shared types for the indexed remap element index unit.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package remap_idx_pkg;
    typedef enum logic [1:0] {
        MAP_LIN = 2'd0,
        MAP_MOD = 2'd1,
        MAP_TRN = 2'd2
    } map_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DIV   = 3'd1,
        ST_LOAD  = 3'd2,
        ST_READY = 3'd3,
        ST_STEP  = 3'd4
    } unit_state_e;
endpackage

// File: rtl/remap_ceildiv.sv
// Iterative ceiling divider: quot = ceil(num/den) and prod = quot*den.
// Assumes num >= 1 and den >= 1 at start, and that NUM_W >= width of den.
module remap_ceildiv #(
    parameter int NUM_W = 7,
    parameter int DEN_W = 6,
    parameter int PRD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot,
    output logic [PRD_W-1:0] prod
);
    logic [NUM_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic             run_q;
    logic [NUM_W-1:0] den_ext;

    assign den_ext = NUM_W'(den_q);

    // Subtract the divisor once per cycle until the remainder is used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
            quot  <= '0;
            prod  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= num;
                den_q <= den;
                quot  <= '0;
                prod  <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                quot <= quot + 1'b1;
                prod <= prod + PRD_W'(den_q);
                if (rem_q > den_ext) begin
                    rem_q <= rem_q - den_ext;
                end else begin
                    rem_q <= '0;
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/remap_stepmap.sv
// Maps a loop step to a position: linear, step mod xdim, or transposed
// (step mod ydim)*xdim + step div ydim, using a subtract-and-count loop.
// Assumes xdim >= 1, ydim >= 1, and mode/xdim/ydim stable while running.
module remap_stepmap
    import remap_idx_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int XD_W  = 6,
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  map_mode_e        mode,
    input  logic [CNT_W-1:0] step,
    input  logic [XD_W-1:0]  xdim,
    input  logic [CNT_W-1:0] ydim,
    output logic             done,
    output logic [POS_W-1:0] pos
);
    logic [CNT_W-1:0] r_q;
    logic [CNT_W-1:0] q_q;
    logic             run_q;
    logic [CNT_W-1:0] divisor;

    // Pick the divisor for the active reshaping mode.
    always_comb begin
        divisor = (mode == MAP_MOD) ? CNT_W'(xdim) : ydim;
    end

    // Reduce the remainder one divisor per cycle, then form the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q   <= '0;
            q_q   <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
            pos   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                r_q   <= step;
                q_q   <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (mode == MAP_LIN) begin
                    pos   <= POS_W'(r_q);
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end else if (r_q >= divisor) begin
                    r_q <= r_q - divisor;
                    q_q <= q_q + 1'b1;
                end else begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                    if (mode == MAP_MOD) begin
                        pos <= POS_W'(r_q);
                    end else begin
                        pos <= POS_W'(r_q) * POS_W'(xdim) + POS_W'(q_q);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/remap_idx_cache.sv
// Local snapshot of the index registers: one write port, one combinational
// read port. Assumes contents are don't-care until written.
module remap_idx_cache #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one fetched register per cycle during the load phase.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/remap_idx_unit.sv
// Indexed remap element index unit. On cfg_start it captures the shape, finds
// ydim = ceil(maxvl/xdim) iteratively, then copies the index registers from
// base = {cfg_base,2'b00} into a cache. Each step request is then reshaped and
// looked up. Assumes reg_rd_data answers reg_rd_num in the same cycle.
module remap_idx_unit
    import remap_idx_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int DIM_W  = 5,
    parameter int BASE_W = 5,
    parameter int ELEM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [CNT_W-1:0]  cfg_maxvl,
    input  logic [DIM_W-1:0]  cfg_dim_code,
    input  logic              cfg_yx,
    input  logic              cfg_skip,
    input  logic [BASE_W-1:0] cfg_base,
    output logic [BASE_W+1:0] reg_rd_num,
    input  logic [ELEM_W-1:0] reg_rd_data,
    input  logic              step_start,
    input  logic [CNT_W-1:0]  step_idx,
    output logic              busy,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_elem,
    output logic [BASE_W+1:0] out_reg
);
    localparam int REG_W = BASE_W + 2;
    localparam int XD_W  = DIM_W + 1;
    localparam int POS_W = CNT_W + 1;

    unit_state_e      state_q;
    map_mode_e        mode_q;
    map_mode_e        mode_d;
    logic [REG_W-1:0] base_q;
    logic [XD_W-1:0]  xdim_q;
    logic [CNT_W-1:0] maxvl_q;
    logic [POS_W-1:0] ld_cnt_q;
    logic [POS_W-1:0] ld_total_q;

    logic             accept_cfg;
    logic             accept_step;
    logic [CNT_W-1:0] eff_maxvl;
    logic [XD_W-1:0]  xdim_in;
    logic             div_done;
    logic [CNT_W-1:0] div_quot;
    logic [POS_W-1:0] div_prod;
    logic             map_done;
    logic [POS_W-1:0] map_pos;
    logic [ELEM_W-1:0] cache_rd;

    assign busy        = (state_q == ST_DIV) || (state_q == ST_LOAD) || (state_q == ST_STEP);
    assign accept_cfg  = cfg_start && !busy;
    assign accept_step = step_start && (state_q == ST_READY) && !cfg_start;
    assign eff_maxvl   = (cfg_maxvl == '0) ? CNT_W'(1) : cfg_maxvl;
    assign xdim_in     = XD_W'(cfg_dim_code) + XD_W'(1);
    assign reg_rd_num  = base_q + REG_W'(ld_cnt_q);

    // Choose the reshaping variant from the configuration flags.
    always_comb begin
        if (cfg_skip)                 mode_d = MAP_LIN;
        else if (cfg_yx)              mode_d = MAP_TRN;
        else if (cfg_dim_code == '0)  mode_d = MAP_LIN;
        else                          mode_d = MAP_MOD;
    end

    remap_ceildiv #(
        .NUM_W(CNT_W),
        .DEN_W(XD_W),
        .PRD_W(POS_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept_cfg),
        .num   (eff_maxvl),
        .den   (xdim_in),
        .done  (div_done),
        .quot  (div_quot),
        .prod  (div_prod)
    );

    remap_stepmap #(
        .CNT_W(CNT_W),
        .XD_W (XD_W),
        .POS_W(POS_W)
    ) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept_step),
        .mode  (mode_q),
        .step  (step_idx),
        .xdim  (xdim_q),
        .ydim  (div_quot),
        .done  (map_done),
        .pos   (map_pos)
    );

    remap_idx_cache #(
        .AW(POS_W),
        .DW(ELEM_W)
    ) u_cache (
        .clk     (clk),
        .wr_en   (state_q == ST_LOAD),
        .wr_addr (ld_cnt_q),
        .wr_data (reg_rd_data),
        .rd_addr (map_pos),
        .rd_data (cache_rd)
    );

    // Sequence configuration, cache load and step computation; hold results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= MAP_LIN;
            base_q     <= '0;
            xdim_q     <= XD_W'(1);
            maxvl_q    <= CNT_W'(1);
            ld_cnt_q   <= '0;
            ld_total_q <= POS_W'(1);
            out_valid  <= 1'b0;
            out_elem   <= '0;
            out_reg    <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_READY: begin
                    if (accept_cfg) begin
                        mode_q    <= mode_d;
                        base_q    <= {cfg_base, 2'b00};
                        xdim_q    <= xdim_in;
                        maxvl_q   <= eff_maxvl;
                        out_valid <= 1'b0;
                        state_q   <= ST_DIV;
                    end else if (accept_step) begin
                        out_valid <= 1'b0;
                        state_q   <= ST_STEP;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        ld_total_q <= (mode_q == MAP_TRN) ? div_prod : POS_W'(maxvl_q);
                        ld_cnt_q   <= '0;
                        state_q    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    ld_cnt_q <= ld_cnt_q + 1'b1;
                    if (ld_cnt_q == ld_total_q - 1'b1) begin
                        state_q <= ST_READY;
                    end
                end
                ST_STEP: begin
                    if (map_done) begin
                        out_valid <= 1'b1;
                        out_elem  <= cache_rd;
                        out_reg   <= base_q + REG_W'(map_pos);
                        state_q   <= ST_READY;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/remap_idx_checker.sv
// Property checker for remap_idx_unit, attached by bind below.
// Assumes the internal mode, base and xdim registers are exposed to it.
module remap_idx_checker
    import remap_idx_pkg::*;
#(
    parameter int REG_W  = 7,
    parameter int XD_W   = 6,
    parameter int ELEM_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_start,
    input logic              step_start,
    input logic              busy,
    input logic              out_valid,
    input logic [ELEM_W-1:0] out_elem,
    input logic [REG_W-1:0]  out_reg,
    input map_mode_e         mode,
    input logic [REG_W-1:0]  base,
    input logic [XD_W-1:0]   xdim
);
    logic [REG_W-1:0] offs;
    assign offs = out_reg - base;

    // R9: a result is never presented while work is in progress.
    p_busy_excl_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid);

    // R9: a presented result holds until a new request arrives.
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !step_start && !cfg_start) |=>
            (out_valid && $stable(out_elem) && $stable(out_reg)));

    // R8: an accepted configuration drops the old result and starts work.
    p_cfg_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && !busy) |=> (busy && !out_valid));

    // R4: in modulo mode the register offset stays below the first dimension.
    p_mod_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode == MAP_MOD) |-> (offs < REG_W'(xdim)));
endmodule

bind remap_idx_unit remap_idx_checker #(
    .REG_W (BASE_W + 2),
    .XD_W  (DIM_W + 1),
    .ELEM_W(ELEM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_start (cfg_start),
    .step_start(step_start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_elem  (out_elem),
    .out_reg   (out_reg),
    .mode      (mode_q),
    .base      (base_q),
    .xdim      (xdim_q)
);

// File: tb/sim_remap_idx_unit.sv
module sim_remap_idx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_start = 1'b0;
    logic [6:0] cfg_maxvl = '0;
    logic [4:0] cfg_dim_code = '0;
    logic       cfg_yx = 1'b0;
    logic       cfg_skip = 1'b0;
    logic [4:0] cfg_base = '0;
    logic [6:0] reg_rd_num;
    logic [7:0] reg_rd_data;
    logic       step_start = 1'b0;
    logic [6:0] step_idx = '0;
    logic       busy;
    logic       out_valid;
    logic [7:0] out_elem;
    logic [6:0] out_reg;

    logic [7:0] rf   [128];
    logic [7:0] snap [128];

    int checks = 0;
    int fails  = 0;
    int q_elem[$];
    int q_reg[$];
    string q_tag[$];
    logic prev_v = 1'b0;

    always #5 clk = ~clk;

    assign reg_rd_data = rf[reg_rd_num];

    remap_idx_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_maxvl(cfg_maxvl),
        .cfg_dim_code(cfg_dim_code), .cfg_yx(cfg_yx), .cfg_skip(cfg_skip),
        .cfg_base(cfg_base), .reg_rd_num(reg_rd_num), .reg_rd_data(reg_rd_data),
        .step_start(step_start), .step_idx(step_idx), .busy(busy),
        .out_valid(out_valid), .out_elem(out_elem), .out_reg(out_reg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill_rf(input int seed);
        for (int r = 0; r < 128; r++) rf[r] = 8'((r * 7 + seed * 13 + 3) & 255);
    endtask

    function automatic int exp_pos(input int i);
        int xd, mv, yd;
        xd = int'(cfg_dim_code) + 1;
        mv = (cfg_maxvl == 0) ? 1 : int'(cfg_maxvl);
        if (cfg_skip) return i;
        if (!cfg_yx) return (xd == 1) ? i : (i % xd);
        yd = (mv + xd - 1) / xd;
        return (i % yd) * xd + (i / yd);
    endfunction

    task automatic configure(input int mv, input int code, input bit yx, input bit sk,
                             input int base, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        cfg_maxvl = 7'(mv); cfg_dim_code = 5'(code); cfg_yx = yx; cfg_skip = sk;
        cfg_base = 5'(base);
        for (int r = 0; r < 128; r++) snap[r] = rf[r];
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        chk(!out_valid && busy, tag, int'(out_valid), 0);
        while (busy) @(negedge clk);
    endtask

    task automatic do_step(input int i, input string tag);
        int p, rn;
        @(negedge clk);
        while (busy) @(negedge clk);
        p  = exp_pos(i);
        rn = (int'(cfg_base) * 4 + p) & 127;
        q_elem.push_back(int'(snap[rn]));
        q_reg.push_back(rn);
        q_tag.push_back(tag);
        step_idx = 7'(i);
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        while (!out_valid) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each new result against the scoreboard.
    always @(negedge clk) begin
        if (out_valid && !prev_v) begin
            if (q_tag.size() == 0) begin
                chk(1'b0, "unexpected result", int'(out_reg), -1);
            end else begin
                int e, r;
                string t;
                e = q_elem.pop_front();
                r = q_reg.pop_front();
                t = q_tag.pop_front();
                chk(int'(out_reg) == r, {t, " reg"}, int'(out_reg), r);
                chk(int'(out_elem) == e, {t, " elem"}, int'(out_elem), e);
            end
        end
        prev_v <= out_valid;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] held;
        fill_rf(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1 reset valid", int'(out_valid), 0);
        chk(!busy, "R1 reset busy", int'(busy), 0);
        step_start = 1'b1;
        @(negedge clk);
        step_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!out_valid && !busy, "R1 step before config", int'(out_valid) + int'(busy), 0);

        // R4 / R3: modulo 4 over 11 elements, base 5
        configure(11, 3, 1'b0, 1'b0, 5, "R8 cfg clears");
        for (int i = 0; i < 11; i++) do_step(i, "R4 R3 modulo");

        // R9: held result stays stable
        held = out_elem;
        repeat (6) @(negedge clk);
        chk(out_valid && out_elem == held, "R9 hold", int'(out_elem), int'(held));

        // R5: dimension 1 and dimension >= VL give linear order
        configure(10, 0, 1'b0, 1'b0, 2, "R8 cfg clears");
        for (int i = 0; i < 10; i++) do_step(i, "R5 dim one");
        configure(10, 20, 1'b0, 1'b0, 9, "R8 cfg clears");
        for (int i = 0; i < 10; i++) do_step(i, "R5 dim large");

        // R6: transposed, uneven (xdim 3, maxvl 10) and even (xdim 4, maxvl 12)
        configure(10, 2, 1'b1, 1'b0, 3, "R8 cfg clears");
        for (int i = 0; i < 10; i++) do_step(i, "R6 transpose ceil");
        configure(12, 3, 1'b1, 1'b0, 7, "R8 cfg clears");
        for (int i = 0; i < 12; i++) do_step(i, "R6 transpose exact");

        // R7: skip forces linear
        configure(9, 2, 1'b1, 1'b1, 4, "R8 cfg clears");
        for (int i = 0; i < 9; i++) do_step(i, "R7 skip");

        // R2: base 31 wraps register numbers past 127
        configure(8, 0, 1'b0, 1'b0, 31, "R8 cfg clears");
        for (int i = 0; i < 8; i++) do_step(i, "R2 base wrap");

        // R8: register rewrites after load are not seen; maxvl 0 acts as 1
        configure(6, 2, 1'b0, 1'b0, 10, "R8 cfg clears");
        fill_rf(5);
        for (int i = 0; i < 6; i++) do_step(i, "R8 snapshot");
        configure(0, 4, 1'b1, 1'b0, 0, "R8 cfg clears");
        do_step(0, "R8 maxvl zero");

        repeat (4) @(negedge clk);
        chk(q_tag.size() == 0, "R9 all results seen", q_tag.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule